// File: doc/BRIEF.md
# Bank and Page Select Unit

This unit holds the two registers that extend a small instruction word's reach. The first is a data bank register, which supplies the upper bits of every direct data address. The second is a program page latch, which supplies the upper bits of the program counter when an absolute jump or call is taken. The unit takes one decoded operation per cycle. A bank literal load and a page literal load each finish in one cycle. A jump or call carries an 11-bit immediate, takes two cycles, and the unit drives its full target address one cycle after the operation is accepted.

The immediate alone only reaches a 2K-word window. To reach any of the 16 windows, software first loads the page latch and then issues the branch. That pair is two words and three cycles. The unit also throttles the operation stream itself: after it accepts a branch it drops `op_ready` for one cycle, and that cycle stands for the pipeline flush.

Top module: `bank_page_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bank_q` and `page_q` are 0, `br_valid` and `br_call` are 0, and `op_ready` is 1.
- R2: An accepted bank load (`op_valid` and `op_ready` high, `op_kind` = 2'b01) sets `bank_q` to `op_lit[4:0]` at the next clock edge. Literal bits [10:5] have no effect.
- R3: `data_addr` equals `{bank_q, data_ofs}`, with the bank in bits [11:7]. In the cycle where a bank load is applied, `data_addr` still uses the old bank.
- R4: An accepted page load (`op_kind` = 2'b10) sets `page_q` to `op_lit[6:0]` at the next edge. It takes one cycle, so `op_ready` stays high.
- R5: An accepted branch (`op_kind` = 2'b11) makes `br_valid` high one cycle later with `br_pc = {page_q[6:3], op_lit[10:0]}`. `page_q[2:0]` has no effect on the target.
- R6: `br_valid` is high for exactly one cycle per branch. `br_call` shows the `op_call` value given with that branch.
- R7: After a branch is accepted, `op_ready` is low for exactly one cycle. An operation offered in that cycle is dropped and changes no state.
- R8: A branch leaves `bank_q` and `page_q` unchanged.
- R9: With `op_valid` low, or with `op_kind` = 2'b00 (no operation), no register changes and `br_valid` stays low.
- R10: A page load followed in the very next cycle by a branch uses the newly loaded page, so any 15-bit target can be reached in three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded operation is offered |
| op_kind | input | 2 | 00 none, 01 bank load, 10 page load, 11 branch |
| op_call | input | 1 | Branch is a call (1) or a jump (0) |
| op_lit | input | 11 | Literal or branch immediate |
| data_ofs | input | 7 | Offset of a direct data access |
| op_ready | output | 1 | Unit accepts an operation this cycle |
| bank_q | output | 5 | Current data bank |
| page_q | output | 7 | Program page latch |
| data_addr | output | 12 | Full direct data address |
| br_valid | output | 1 | Branch target valid, one-cycle pulse |
| br_call | output | 1 | The valid branch is a call |
| br_pc | output | 15 | Absolute branch target |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a bank load and a direct data access. The bench applies a bank load and reads `data_addr` before the clock edge, where it must still show the old bank, then reads it again after the edge, where it must show the new one. The second pair is the flush cycle of a branch and a newly arriving operation. The bench offers a bank load while `op_ready` is low and judges it by seeing `bank_q` unchanged afterwards. Back-to-back page load and branch are also checked, to show the fresh page reaches the target.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_BANK = 2'b01,
    OP_PAGE = 2'b10,
    OP_JUMP = 2'b11
  } bpu_op_e;
endpackage

// File: rtl/bpu_lit_reg.sv
module bpu_lit_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] lit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= lit;
  end

  // R2 / R4 / R8 / R9: the register only moves on an accepted load
  a_r9_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  a_r2_load_takes_literal: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(lit));
endmodule

// File: rtl/bpu_flush_ctrl.sv
module bpu_flush_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic take_branch,
  output logic ready
);
  logic flush_q;

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= take_branch;
  end

  assign ready = ~flush_q;

  a_r7_single_stall: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ready);
  a_r7_stall_after_branch: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> !ready);
endmodule

// File: rtl/bpu_branch_former.sv
module bpu_branch_former #(
  parameter int IMM_W = 11,
  parameter int SEL_W = 4,
  localparam int PC_W = IMM_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_branch,
  input  logic             is_call,
  input  logic [IMM_W-1:0] imm,
  input  logic [SEL_W-1:0] page_sel,
  output logic             br_valid,
  output logic             br_call,
  output logic [PC_W-1:0]  br_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      br_valid <= 1'b0;
      br_call  <= 1'b0;
      br_pc    <= '0;
    end else begin
      br_valid <= take_branch;
      if (take_branch) begin
        br_call <= is_call;
        br_pc   <= {page_sel, imm};
      end else begin
        br_call <= 1'b0;
      end
    end
  end

  a_r6_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> !br_valid);
  a_r6_call_only_when_valid: assert property (@(posedge clk) disable iff (rst)
    br_call |-> br_valid);
endmodule

// File: rtl/bank_page_unit.sv
module bank_page_unit #(
  parameter int BANK_W = 5,
  parameter int OFS_W  = 7,
  parameter int PAGE_W = 7,
  parameter int SEL_W  = 4,
  parameter int IMM_W  = 11,
  localparam int PC_W   = IMM_W + SEL_W,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_call,
  input  logic [IMM_W-1:0]  op_lit,
  input  logic [OFS_W-1:0]  data_ofs,
  output logic              op_ready,
  output logic [BANK_W-1:0] bank_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [ADDR_W-1:0] data_addr,
  output logic              br_valid,
  output logic              br_call,
  output logic [PC_W-1:0]   br_pc
);
  import bpu_pkg::*;

  bpu_op_e kind;
  logic    accept, ld_bank, ld_page, take_br;

  assign kind    = bpu_op_e'(op_kind);
  assign accept  = op_valid & op_ready;
  assign ld_bank = accept & (kind == OP_BANK);
  assign ld_page = accept & (kind == OP_PAGE);
  assign take_br = accept & (kind == OP_JUMP);

  bpu_lit_reg #(.W(BANK_W)) u_bank (
    .clk(clk), .rst(rst), .load(ld_bank),
    .lit(op_lit[BANK_W-1:0]), .q(bank_q)
  );

  bpu_lit_reg #(.W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .load(ld_page),
    .lit(op_lit[PAGE_W-1:0]), .q(page_q)
  );

  bpu_flush_ctrl u_flush (
    .clk(clk), .rst(rst), .take_branch(take_br), .ready(op_ready)
  );

  bpu_branch_former #(.IMM_W(IMM_W), .SEL_W(SEL_W)) u_branch (
    .clk(clk), .rst(rst), .take_branch(take_br), .is_call(op_call),
    .imm(op_lit), .page_sel(page_q[PAGE_W-1:PAGE_W-SEL_W]),
    .br_valid(br_valid), .br_call(br_call), .br_pc(br_pc)
  );

  assign data_addr = {bank_q, data_ofs};

  // R5: the target's upper bits match the page latch (unchanged during the flush)
  a_r5_page_in_target: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> br_pc[PC_W-1:IMM_W] == page_q[PAGE_W-1:PAGE_W-SEL_W]);
  // R7: a valid target always coincides with the flush stall
  a_r7_flush_with_target: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> !op_ready);
  // R8: a branch does not touch bank or page
  a_r8_branch_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    take_br |=> $stable(bank_q) && $stable(page_q));
endmodule

// File: tb/bank_page_unit_tb.sv
module bank_page_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic        op_call;
  logic [10:0] op_lit;
  logic [6:0]  data_ofs;
  logic        op_ready;
  logic [4:0]  bank_q;
  logic [6:0]  page_q;
  logic [11:0] data_addr;
  logic        br_valid, br_call;
  logic [14:0] br_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bank_page_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_call(op_call), .op_lit(op_lit), .data_ofs(data_ofs),
    .op_ready(op_ready), .bank_q(bank_q), .page_q(page_q),
    .data_addr(data_addr), .br_valid(br_valid), .br_call(br_call),
    .br_pc(br_pc)
  );

  // {kind, call, lit, exp_bank, exp_page, exp_brv, exp_brcall, exp_pc}
  localparam int NV = 12;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 1'b0, 11'h7F3, 5'h13, 7'h00, 1'b0, 1'b0, 15'h0000},
    {2'd2, 1'b0, 11'h0A5, 5'h13, 7'h25, 1'b0, 1'b0, 15'h0000},
    {2'd3, 1'b0, 11'h123, 5'h13, 7'h25, 1'b1, 1'b0, 15'h2123},
    {2'd0, 1'b0, 11'h000, 5'h13, 7'h25, 1'b0, 1'b0, 15'h0000},
    {2'd2, 1'b0, 11'h07F, 5'h13, 7'h7F, 1'b0, 1'b0, 15'h0000},
    {2'd3, 1'b1, 11'h7FF, 5'h13, 7'h7F, 1'b1, 1'b1, 15'h7FFF},
    {2'd0, 1'b0, 11'h000, 5'h13, 7'h7F, 1'b0, 1'b0, 15'h0000},
    {2'd2, 1'b0, 11'h007, 5'h13, 7'h07, 1'b0, 1'b0, 15'h0000},
    {2'd3, 1'b0, 11'h000, 5'h13, 7'h07, 1'b1, 1'b0, 15'h0000},
    {2'd0, 1'b0, 11'h000, 5'h13, 7'h07, 1'b0, 1'b0, 15'h0000},
    {2'd1, 1'b0, 11'h01F, 5'h1F, 7'h07, 1'b0, 1'b0, 15'h0000},
    {2'd1, 1'b0, 11'h7E0, 5'h00, 7'h07, 1'b0, 1'b0, 15'h0000}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic c, input logic [10:0] l);
    @(negedge clk);
    op_valid = v; op_kind = k; op_call = c; op_lit = l;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_kind = 2'd0; op_call = 1'b0;
    op_lit = '0; data_ofs = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(bank_q == 0 && page_q == 0, "R1 regs in reset", {bank_q, page_q}, 0);
    chk(!br_valid && !br_call && op_ready, "R1 flags in reset", {br_valid, br_call, op_ready}, 1);
    @(negedge clk); rst = 1'b0;
    tick();
    chk(bank_q == 0 && page_q == 0 && !br_valid && op_ready, "R1 after release",
        {bank_q, page_q, br_valid, op_ready}, 1);

    // vector walk: R2 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      drive(1'b1, v[42:41], v[40], v[39:29]);
      tick();
      chk(bank_q == v[28:24], $sformatf("R2 bank row %0d", i), bank_q, v[28:24]);
      chk(page_q == v[23:17], $sformatf("R4 page row %0d", i), page_q, v[23:17]);
      chk(br_valid == v[16], $sformatf("R6 br_valid row %0d", i), br_valid, v[16]);
      if (v[16]) begin
        chk(br_pc == v[14:0], $sformatf("R5 br_pc row %0d", i), br_pc, v[14:0]);
        chk(br_call == v[15], $sformatf("R6 br_call row %0d", i), br_call, v[15]);
        chk(!op_ready, $sformatf("R7 stall row %0d", i), op_ready, 0);
      end else begin
        chk(op_ready, $sformatf("R4 ready row %0d", i), op_ready, 1);
      end
    end

    // R7: an operation offered during the flush is dropped
    drive(1'b1, 2'd3, 1'b0, 11'h055);
    tick();
    chk(br_valid && br_pc == 15'h0055, "R5 target page 7", br_pc, 15'h0055);
    drive(1'b1, 2'd1, 1'b0, 11'h00A);
    chk(!op_ready, "R7 ready low in flush", op_ready, 0);
    tick();
    chk(bank_q == 5'h00, "R7 dropped load", bank_q, 0);
    chk(op_ready && !br_valid, "R7 ready back", {op_ready, br_valid}, 2);
    drive(1'b1, 2'd1, 1'b0, 11'h00A);
    tick();
    chk(bank_q == 5'h0A, "R2 reissued load", bank_q, 5'h0A);

    // R3: address formation, old bank in the load cycle
    data_ofs = 7'h45; #1;
    chk(data_addr == 12'h545, "R3 addr", data_addr, 12'h545);
    drive(1'b1, 2'd1, 1'b0, 11'h003);
    chk(data_addr == 12'h545, "R3 old bank same cycle", data_addr, 12'h545);
    tick();
    chk(data_addr == 12'h1C5, "R3 new bank", data_addr, 12'h1C5);

    // R9: invalid or empty operation
    drive(1'b0, 2'd1, 1'b0, 11'h01F);
    tick();
    chk(bank_q == 5'h03, "R9 valid low", bank_q, 5'h03);
    drive(1'b1, 2'd0, 1'b1, 11'h7FF);
    tick();
    chk(bank_q == 5'h03 && page_q == 7'h07 && !br_valid, "R9 no-op",
        {bank_q, page_q, br_valid}, {5'h03, 7'h07, 1'b0});
    drive(1'b0, 2'd3, 1'b0, 11'h123);
    tick();
    chk(!br_valid && op_ready, "R9 branch not valid", {br_valid, op_ready}, 1);

    // R10: page load then branch in the next cycle
    drive(1'b1, 2'd2, 1'b0, 11'h048);
    tick();
    drive(1'b1, 2'd3, 1'b1, 11'h001);
    tick();
    chk(br_valid && br_pc == 15'h4801, "R10 back-to-back target", br_pc, 15'h4801);
    chk(br_call, "R6 call flag", br_call, 1);

    // R1: reset in mid-run
    drive(1'b0, 2'd0, 1'b0, 11'h000);
    rst = 1'b1;
    tick();
    chk(bank_q == 0 && page_q == 0 && !br_valid && op_ready, "R1 mid-run reset",
        {bank_q, page_q, br_valid, op_ready}, 1);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule